// File: doc/BRIEF.md
# Handshake Sample-Rate Transition Stage

This stage sits in a valid/ready stream and changes the number of samples per unit of work by a fixed integer ratio. No clock-based sample timing is involved: the rate change comes only from the order in which input and output transfers complete. Each transfer finishes only when both sides of its handshake agree.

A compile-time mode selects one of two behaviours. In up-sampling mode the stage holds one sample and sends it out a fixed number of times. Only after that does it accept the next input. Because output comes first, the stream is delayed by one sample, and the reset value of the register leads the output. In down-sampling mode the stage accepts a group of inputs into the same register. It then sends only the last sample of that group, once.

The stage stores samples and does no arithmetic. A small counter follows the transfers inside the current phase. A phase flag selects which side of the stage is open.

Top module: `rate_xfer_stage`

## Requirements
- R1: After reset the sample register is 0. In up-sampling mode `out_valid` is 1, `out_data` is 0 and `in_ready` is 0. In down-sampling mode `in_ready` is 1 and `out_valid` is 0.
- R2: In up-sampling mode every held value is sent on exactly RATIO output handshakes before the next input is accepted.
- R3: In up-sampling mode `in_ready` is 1 only after RATIO outputs of the current value have completed. After an input handshake `out_valid` returns at the next cycle with the new sample.
- R4: In up-sampling mode the first RATIO outputs after reset carry the value 0, and the k-th accepted input appears on outputs k*RATIO+RATIO through k*RATIO+2*RATIO-1 (counting from 0).
- R5: In down-sampling mode RATIO input handshakes fill the register, and the single output that follows carries the last of those RATIO samples.
- R6: In down-sampling mode `out_valid` is 1 only after RATIO inputs of the current group have been accepted. It drops on the cycle after its output handshake, and `in_ready` rises at that same cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 and the same `out_data`.
- R8: With RATIO = 1 both modes act as a one-entry register that alternates between input and output. In up-sampling mode the output still trails the input by one sample, beginning with 0.
- R9: `in_data` is ignored while `in_ready` is 0. The value held, and so `out_data`, does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a sample |
| in_ready | output | 1 | Stage accepts a sample this cycle |
| in_data | input | W | Sample offered by upstream |
| out_valid | output | 1 | Stage offers the held sample |
| out_ready | input | 1 | Downstream accepts the offered sample |
| out_data | output | W | Held sample |

## Verification
The bench targets the phase turn-over at the last transfer of a group. A counter that is off by one would repeat a value RATIO+1 or RATIO-1 times, or would forward the first sample of a group instead of the last. It runs RATIO = 1, where a design that treats the counter limit wrongly would never leave its first phase. It presents junk data while the input side is closed, which catches a register that loads on `in_valid` alone. It also holds back downstream for long stretches, which shows any output that moves or drops without a handshake.

// File: rtl/rate_xfer_stage.sv
module rate_xfer_stage #(
  parameter int W        = 16,
  parameter int RATIO    = 5,
  parameter bit UPSAMPLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic          emit;
  logic [CW-1:0] cnt;
  logic [W-1:0]  hold;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;
  wire at_last  = (cnt == LAST);

  assign in_ready  = !emit;
  assign out_valid = emit;
  assign out_data  = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit <= UPSAMPLE;
      cnt  <= '0;
      hold <= '0;
    end else begin
      if (in_fire) hold <= in_data;
      if (UPSAMPLE) begin
        if (out_fire) begin
          cnt <= at_last ? '0 : cnt + 1'b1;
          if (at_last) emit <= 1'b0;
        end
        if (in_fire) emit <= 1'b1;
      end else begin
        if (in_fire) begin
          cnt <= at_last ? '0 : cnt + 1'b1;
          if (at_last) emit <= 1'b1;
        end
        if (out_fire) emit <= 1'b0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(out_data));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_data == $past(in_data));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  generate
    if (UPSAMPLE) begin : g_up
      p_stay_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !at_last |=> out_valid && !in_ready);
      p_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !in_ready);
    end else begin : g_down
      p_stay_acq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !at_last |=> in_ready && !out_valid);
      p_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> in_ready && !out_valid);
    end
  endgenerate

endmodule

// File: tb/sim_rate_xfer_stage.sv
module sim_rate_xfer_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NR[NI] = '{5, 5, 1, 1};
  localparam bit UP[NI] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int NPH = 4;
  localparam logic [15:0] PAT_IN[NPH]  = '{16'hFFFF, 16'hAAAA, 16'hF0F3, 16'h7FFE};
  localparam logic [15:0] PAT_OUT[NPH] = '{16'hFFFF, 16'hCCCC, 16'h00FF, 16'hF7DB};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv [NI];
  logic ir [NI];
  logic ov [NI];
  logic ordy [NI];
  logic [15:0] idt [NI];
  logic [15:0] odt [NI];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int ins [NI];
  int outs [NI];
  bit prev_stall [NI];
  logic [15:0] prev_od [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar gi = 0; gi < NI; gi++) begin : g
    rate_xfer_stage #(.W(16), .RATIO(NR[gi]), .UPSAMPLE(UP[gi])) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(iv[gi]), .in_ready(ir[gi]), .in_data(idt[gi]),
      .out_valid(ov[gi]), .out_ready(ordy[gi]), .out_data(odt[gi]));
  end

  function automatic logic [15:0] seqv(int i, int k);
    return 16'(i * 16'h1111 + k * 16'h0123 + 1);
  endfunction

  function automatic logic [15:0] expect_out(int i, int k);
    if (UP[i]) return (k < NR[i]) ? 16'h0000 : seqv(i, k / NR[i] - 1);
    return seqv(i, (k + 1) * NR[i] - 1);
  endfunction

  task automatic chk(bit ok, string req, int i, int act, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst=%0d actual=%h expected=%h", req, i, act, exp_v);
    end
  endtask

  initial begin
    for (int i = 0; i < NI; i++) begin
      iv[i] = 1'b0; ordy[i] = 1'b0; idt[i] = 16'h0;
      ins[i] = 0; outs[i] = 0; prev_stall[i] = 1'b0; prev_od[i] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < NI; i++) begin
      chk(odt[i] == 16'h0, "R1", i, odt[i], 0);
      chk(ov[i] == UP[i], "R1", i, ov[i], UP[i]);
      chk(ir[i] == !UP[i], "R1", i, ir[i], !UP[i]);
    end

    for (int p = 0; p < NPH; p++) begin
      for (int c = 0; c < 50; c++) begin
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
          iv[i]   = PAT_IN[p][(c + i) % 16];
          ordy[i] = PAT_OUT[p][(c + 3 * i) % 16];
          idt[i]  = ir[i] ? seqv(i, ins[i]) : (16'hBAD0 ^ 16'(i));
        end
        #1;
        for (int i = 0; i < NI; i++) begin
          bit exp_ov;
          if (UP[i]) begin
            exp_ov = !(outs[i] == NR[i] * (ins[i] + 1));
            chk(ir[i] == !exp_ov, (NR[i] == 1) ? "R8" : "R3", i, ir[i], !exp_ov);
          end else begin
            exp_ov = (ins[i] == NR[i] * (outs[i] + 1));
            chk(ov[i] == exp_ov, (NR[i] == 1) ? "R8" : "R6", i, ov[i], exp_ov);
          end
          if (prev_stall[i]) begin
            chk(ov[i] && odt[i] == prev_od[i], "R7", i, odt[i], prev_od[i]);
          end
          if (ov[i] && ordy[i]) begin
            chk(odt[i] == expect_out(i, outs[i]),
                (NR[i] == 1) ? "R8" : (UP[i] ? ((outs[i] < NR[i]) ? "R4" : "R2") : "R5"),
                i, odt[i], expect_out(i, outs[i]));
            outs[i]++;
          end
          if (iv[i] && ir[i]) ins[i]++;
          prev_stall[i] = ov[i] && !ordy[i];
          prev_od[i] = odt[i];
        end
      end
    end

    chk(outs[0] >= 20, "R2", 0, outs[0], 20);
    chk(outs[1] >= 3, "R5", 1, outs[1], 3);
    chk(outs[2] >= 10 && ins[2] >= 10, "R8", 2, outs[2], 10);
    chk(outs[3] >= 10, "R8", 3, outs[3], 10);
    chk(ins[0] >= 3, "R9", 0, ins[0], 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule